// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Bus

This block receives control settings from a two-wire serial bus master and keeps them in a bank of eight 8-bit registers that steer an audio signal path: input select, input gain, volume, bass, mid-range, treble, and the right and left speaker attenuators. It is a write-only bus slave. It runs on a system clock and oversamples both bus lines. Each line passes through a two-flop synchronizer and then a three-sample agreement filter, so narrow spikes never reach the protocol logic.

A transfer opens with a START and then sends the device address byte 0x88, which is the 7-bit address 1000100 with a write bit of 0. Next comes a sub-address byte, then any number of data bytes, and a STOP closes the transfer. The sub-address names the first register and also chooses between two modes. In the first, every data byte goes to that same register. In the second, each data byte goes to the next register in turn. Every accepted byte raises a one-cycle strobe together with the register index. All eight registers are always visible as parallel outputs. On reset the registers load power-on values, and two of those values are mute codes.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the register outputs are: sel_q=8'h02, gain_q=8'h0E, vol_q=8'h38 (mute), bass_q=8'h07, mid_q=8'h0E, treb_q=8'h0E, att_r_q=8'h78 (mute), att_l_q=8'h78 (mute). sda_oe is 0.
- R2: After an address byte of 0x88 (bits sent MSB first, sampled while SCL is high), the slave pulls SDA low (sda_oe=1) through the ninth SCL pulse. It does the same after the sub-address byte and after every data byte, until STOP.
- R3: If the address byte is not 0x88, including 0x89 where the read bit is 1, the slave gives no acknowledge and writes nothing. It then ignores the bus until the next START or STOP.
- R4: In the sub-address byte, bits 7..5 have no effect, bit 4 is the increment flag and bits 3..0 are the first register index. The indices are 0 sel_q, 1 gain_q, 2 vol_q, 3 bass_q, 4 mid_q, 5 treb_q, 6 att_r_q and 7 att_l_q.
- R5: When the increment flag is 0, every data byte up to STOP is written to the same index, so the register holds the last byte sent.
- R6: When the increment flag is 1, data byte k (counting from 0) is aimed at index start+k. A byte aimed at index 8..15 is dropped: no register changes and no strobe is raised, but the byte is still acknowledged.
- R7: Each accepted data byte pulses wr_stb high for exactly one clock, with wr_idx giving the index written. The register output shows the new value in the same cycle. When wr_stb is low, no register changes.
- R8: A repeated START (a START with no STOP before it) restarts address reception at once, whatever phase the transfer is in.
- R9: A pulse on SCL or SDA lasting one system clock is filtered out and does not change the result of a transfer.
- R10: After a STOP, bytes clocked without a new START are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| wr_idx | output | 3 | Index of the register written with wr_stb |
| sel_q | output | 8 | Register 0: input select |
| gain_q | output | 8 | Register 1: input gain |
| vol_q | output | 8 | Register 2: volume |
| bass_q | output | 8 | Register 3: bass |
| mid_q | output | 8 | Register 4: mid-range |
| treb_q | output | 8 | Register 5: treble |
| att_r_q | output | 8 | Register 6: right speaker attenuation |
| att_l_q | output | 8 | Register 7: left speaker attenuation |

## Verification
The write of a data byte and the step of the auto-increment index happen on the same filtered SCL falling edge. At index 7 that step moves the index to 8, and every later byte must then be dropped. Bursts are started near index 7, at random start indices and random lengths, with random bits in the unused sub-address field. The result is judged on the final register values, the count of strobes, the last strobed index, and the acknowledge of every byte, all against a bench model of the bank. A one-clock glitch on SCL while it is low, and one on SDA while SCL is high, are injected inside a transfer. They must leave the write unchanged.

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [2:0] wr_idx,
  output logic [7:0] sel_q,
  output logic [7:0] gain_q,
  output logic [7:0] vol_q,
  output logic [7:0] bass_q,
  output logic [7:0] mid_q,
  output logic [7:0] treb_q,
  output logic [7:0] att_r_q,
  output logic [7:0] att_l_q
);

  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} st_t;

  function automatic logic [7:0] rst_val(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h02;
      3'd1:    return 8'h0E;
      3'd2:    return 8'h38;
      3'd3:    return 8'h07;
      3'd4:    return 8'h0E;
      3'd5:    return 8'h0E;
      default: return 8'h78;
    endcase
  endfunction

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0]    scl_h, sda_h;
  logic                   scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_h  <= '1;
      sda_h  <= '1;
      scl_f  <= 1'b1;
      sda_f  <= 1'b1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[SYNC_STAGES-1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d  <= scl_f;
      sda_d  <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [3:0] idx;
  logic       inc;
  logic       ack;
  logic [7:0] bank [8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      idx    <= '0;
      inc    <= 1'b0;
      ack    <= 1'b0;
      wr_stb <= 1'b0;
      wr_idx <= '0;
      for (int i = 0; i < 8; i++) bank[i] <= rst_val(3'(i));
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        ack    <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        ack    <= 1'b0;
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (scl_rise && bitcnt < 4'd8) begin
          sh     <= {sh[6:0], sda_f};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (st)
            S_ADDR:
              if (sh == WR_ADDR) begin
                ack <= 1'b1;
                st  <= S_SUB;
              end else begin
                st  <= S_SKIP;
              end
            S_SUB: begin
              idx <= sh[3:0];
              inc <= sh[4];
              ack <= 1'b1;
              st  <= S_DATA;
            end
            default: begin
              ack <= 1'b1;
              if (!idx[3]) begin
                bank[idx[2:0]] <= sh;
                wr_stb         <= 1'b1;
                wr_idx         <= idx[2:0];
                if (inc) idx <= idx + 4'd1;
              end
            end
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          bitcnt <= '0;
          ack    <= 1'b0;
        end
      end
    end

  assign sda_oe  = ack;
  assign sel_q   = bank[0];
  assign gain_q  = bank[1];
  assign vol_q   = bank[2];
  assign bass_q  = bank[3];
  assign mid_q   = bank[4];
  assign treb_q  = bank[5];
  assign att_r_q = bank[6];
  assign att_l_q = bank[7];

  wire [63:0] bank_flat = {bank[7], bank[6], bank[5], bank[4],
                           bank[3], bank[2], bank[1], bank[0]};

  // R2
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> (!sda_oe && !wr_stb));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(bank_flat));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

endmodule

// File: tb/sim_audio_ctl_i2c_slave.sv
module sim_audio_ctl_i2c_slave;
  localparam int H = 16;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1, scl_gl = 0, sda_gl = 0;
  logic sda_oe, wr_stb;
  logic [2:0] wr_idx;
  logic [7:0] sel_q, gain_q, vol_q, bass_q, mid_q, treb_q, att_r_q, att_l_q;
  wire scl_bus = m_scl ^ scl_gl;
  wire sda_bus = (m_sda ^ sda_gl) & ~sda_oe;

  always #5 clk = ~clk;

  audio_ctl_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .sel_q(sel_q), .gain_q(gain_q), .vol_q(vol_q), .bass_q(bass_q),
    .mid_q(mid_q), .treb_q(treb_q), .att_r_q(att_r_q), .att_l_q(att_l_q));

  int checks = 0, errors = 0;
  int stb_cnt = 0, wide = 0;
  logic [2:0] last_idx = 0;
  logic prev_stb = 0;
  logic [7:0] expv [8];
  logic [7:0] tx [8];

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt++;
      last_idx = wr_idx;
      if (prev_stb) wide++;
    end
    prev_stb = wr_stb;
  end

  function automatic logic [7:0] get_reg(input int i);
    case (i)
      0: return sel_q;
      1: return gain_q;
      2: return vol_q;
      3: return bass_q;
      4: return mid_q;
      5: return treb_q;
      6: return att_r_q;
      default: return att_l_q;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) check(req, get_reg(i), expv[i]);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    m_sda = 1; wt(H/2); m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; wt(H/2);
  endtask

  task automatic bstop;
    m_sda = 0; wt(H/2); m_scl = 1; wt(H); m_sda = 1; wt(H);
  endtask

  task automatic bbyte(input logic [7:0] b, input bit glitch, output bit ackd);
    for (int k = 7; k >= 0; k--) begin
      m_sda = b[k]; wt(H/2);
      if (glitch && k == 4) begin scl_gl = 1; wt(1); scl_gl = 0; end
      m_scl = 1; wt(H/2);
      if (glitch && k == 2) begin sda_gl = 1; wt(1); sda_gl = 0; end
      wt(H/2); m_scl = 0; wt(H/2);
    end
    m_sda = 1; wt(H/2); m_scl = 1; wt(H/2);
    ackd = (sda_bus == 1'b0);
    wt(H/2); m_scl = 0; wt(H/2);
  endtask

  // Full transfer: address, optional sub-address, n data bytes, optional STOP.
  task automatic xfer(input string req, input logic [7:0] addr, input logic [7:0] sub,
                      input int n, input bit with_sub, input bit do_stop, input bit glitch);
    bit a, good, all_ok;
    int s0, exp_stb;
    logic [3:0] ix;
    logic [2:0] exp_last;
    s0 = stb_cnt;
    good = (addr == 8'h88);
    all_ok = 1;
    exp_stb = 0;
    exp_last = last_idx;
    bstart;
    bbyte(addr, 0, a);
    check({req, " addr ack"}, a, good);
    if (with_sub) begin
      bbyte(sub, 0, a);
      if (good && !a) all_ok = 0;
      if (!good && a) all_ok = 0;
      ix = sub[3:0];
      for (int k = 0; k < n; k++) begin
        bbyte(tx[k], glitch && k == 0, a);
        if (good && !a) all_ok = 0;
        if (!good && a) all_ok = 0;
        if (good && !ix[3]) begin
          expv[ix[2:0]] = tx[k];
          exp_stb++;
          exp_last = ix[2:0];
          if (sub[4]) ix = ix + 4'd1;
        end
      end
      check({req, " byte acks"}, all_ok, 1);
    end
    if (do_stop) bstop;
    wt(8);
    check({req, " strobe count"}, stb_cnt - s0, exp_stb);
    if (exp_stb > 0) check({req, " last wr_idx"}, last_idx, exp_last);
    check_regs(req);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    bit a;
    int n;
    logic [7:0] ad, sb;
    void'($urandom(32'd4242));
    expv[0] = 8'h02; expv[1] = 8'h0E; expv[2] = 8'h38; expv[3] = 8'h07;
    expv[4] = 8'h0E; expv[5] = 8'h0E; expv[6] = 8'h78; expv[7] = 8'h78;
    wt(5); rst_n = 1; wt(10);

    // R1 reset state
    check_regs("R1");
    check("R1 sda_oe", sda_oe, 0);

    // R5 same index, R2 acks
    tx[0] = 8'h11; tx[1] = 8'h05; tx[2] = 8'h2A;
    xfer("R5", 8'h88, 8'h02, 3, 1, 1, 0);

    // R6 increment across index 7, junk in bits 7..5 (R4)
    tx[0] = 8'hA1; tx[1] = 8'hB2; tx[2] = 8'hC3; tx[3] = 8'hD4; tx[4] = 8'hE5;
    xfer("R6 R4", 8'h88, 8'hF5, 5, 1, 1, 0);

    // R6 start index above 7: nothing written
    tx[0] = 8'h99; tx[1] = 8'h98;
    xfer("R6 high index", 8'h88, 8'h19, 2, 1, 1, 0);

    // R7 one-cycle strobe with index 0
    tx[0] = 8'h03;
    xfer("R7", 8'h88, 8'h00, 1, 1, 1, 0);
    check("R7 strobe width", wide, 0);

    // R3 wrong address and read bit
    tx[0] = 8'h00; tx[1] = 8'hFF;
    xfer("R3 wrong addr", 8'h8A, 8'h03, 2, 1, 1, 0);
    xfer("R3 read bit", 8'h89, 8'h04, 2, 1, 1, 0);

    // R8 repeated START after sub-address
    xfer("R8 first", 8'h88, 8'h03, 0, 1, 0, 0);
    tx[0] = 8'h55;
    xfer("R8 restart", 8'h88, 8'h01, 1, 1, 1, 0);

    // R8 ignored address, then repeated START recovers (R3)
    xfer("R3 skip", 8'h08, 8'h00, 1, 1, 0, 0);
    tx[0] = 8'h66;
    xfer("R8 after skip", 8'h88, 8'h06, 1, 1, 1, 0);

    // R10 bytes after STOP without START
    n = stb_cnt;
    bbyte(8'h88, 0, a);
    check("R10 no ack", a, 0);
    bbyte(8'h02, 0, a);
    bbyte(8'h00, 0, a);
    wt(8);
    check("R10 no strobe", stb_cnt - n, 0);
    check_regs("R10");

    // R9 glitches inside a transfer
    tx[0] = 8'h5A; tx[1] = 8'hA5;
    xfer("R9 glitch", 8'h88, 8'h13, 2, 1, 1, 1);
    tx[0] = 8'hC3;
    xfer("R9 glitch b", 8'h88, 8'h07, 1, 1, 1, 1);

    // Random mix, biased towards the index 7 boundary (R6)
    for (int t = 0; t < 30; t++) begin
      ad = ($urandom_range(0, 5) == 0) ? (8'h88 ^ (8'h01 << $urandom_range(0, 7))) : 8'h88;
      sb = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) sb[3:0] = 4'(5 + $urandom_range(0, 3));
      n = $urandom_range(1, 6);
      for (int k = 0; k < 8; k++) tx[k] = 8'($urandom_range(0, 255));
      xfer("R6 random", ad, sb, n, 1, 1, 0);
    end
    check("R7 strobe width end", wide, 0);

    finish_run;
  end
endmodule